// File: doc/BRIEF.md
# Pulse Edge Timestamp Unit

This block stamps the rising edges of an asynchronous pulse input, such as a once-per-second timing reference. A divided clock drives two counters of the same width. The reference counter runs freely and supplies the time base. The elapsed counter restarts at zero on every qualifying edge and then counts up at the same rate. It therefore holds the time since the last edge.

A host sends a one-cycle poll strobe. In that clock cycle the block captures the synchronised input level, the reference count and the elapsed count together. On the next cycle it presents the edge time and a flag that marks a new event. The edge time is not stored when the edge occurs. It is rebuilt as the reference count minus the elapsed count, so a poll that arrives late still returns the count the reference held just after the edge. An echo output follows the input level, either true or inverted, for visual indication.

The poll path is a two-state machine. `POLL_IDLE` waits for the strobe. On the transition *capture* (idle with poll high) it snapshots the counters and moves to `POLL_REPORT`. On the transition *publish* (always taken from report) it drives the results and returns to `POLL_IDLE`.

Top module: `evt_timestamp`

## Requirements
- R1: `evt_in` passes through a two-flop synchroniser before any use. A change on `evt_in` that is set up before clock edge k shows in the synchronised level after edge k+1. Only a low-to-high change of the synchronised level counts as an event; a high-to-low change only affects the echo.
- R2: At the clock edge where a rising event is detected, the elapsed counter loads zero. This takes priority over a count tick in the same cycle. From then on it advances together with the reference counter.
- R3: One shared prescaler emits a tick once every `PRESCALE` clocks. Each counter advances by one per tick and wraps modulo 2^`CNT_W`. Between ticks both counters hold their values.
- R4: `stamp` equals `snap_ref - snap_elapsed` modulo 2^`CNT_W`. This is the reference count held in the cycle just after the last event's clear, or 0 if no event has occurred since reset. It holds even when the poll comes more than one counter wrap after the edge.
- R5: `echo_out` is a register that takes (synchronised level XOR `echo_invert`) on every clock, with bit value 1 meaning high. Reset drives it to 0.
- R6: A `poll` that is high at an edge while in `POLL_IDLE` captures the level, the reference count and the elapsed count from the same cycle into `snap_level`, `snap_ref` and `snap_elapsed`. One edge later `stamp` and `stamp_valid` update and `poll_done` is high for exactly one cycle. A `poll` seen while in `POLL_REPORT` is ignored.
- R7: `stamp_valid` is 1 only when the level captured by this poll is 1 and the level captured by the previous poll (0 after reset) was 0. Otherwise it is 0.
- R8: Reset (`rst_n` low, asynchronous) clears both counters, the prescaler, the synchroniser, the previous-poll level, the echo output and all snapshot and result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Asynchronous pulse input to be stamped |
| echo_invert | input | 1 | 1 makes echo_out the inverse of the level |
| poll | input | 1 | Host poll strobe |
| snap_level | output | 1 | Synchronised input level captured at the poll |
| snap_ref | output | CNT_W | Reference count captured at the poll |
| snap_elapsed | output | CNT_W | Elapsed count captured at the poll |
| stamp | output | CNT_W | Rebuilt edge time, snap_ref - snap_elapsed |
| stamp_valid | output | 1 | New rising event seen since the previous poll |
| poll_done | output | 1 | One-cycle pulse when stamp and stamp_valid update |
| echo_out | output | 1 | Level indication, true or inverted |

## Verification
The bench builds the block with `CNT_W = 8` and `PRESCALE = 3`. The counters then wrap every 768 clocks, so polls made long after an edge and several wraps of both counters fit in a short run. The odd divide ratio causes event clears to land in every prescaler phase, including the same cycle as a tick. Random pulse patterns and random poll spacing cover polls that coincide with a rising edge still inside the synchroniser.

// File: rtl/ets_pkg.sv
package ets_pkg;
    typedef enum logic [0:0] {
        POLL_IDLE   = 1'b0,
        POLL_REPORT = 1'b1
    } poll_state_e;
endpackage

// File: rtl/ets_sync.sv
module ets_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
endmodule

// File: rtl/ets_timebase.sv
module ets_timebase #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic             tick,
    output logic [CNT_W-1:0] ref_cnt,
    output logic [CNT_W-1:0] el_cnt
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PW-1:0] pre;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre <= '0;
                else if (pre == PW'(PRESCALE - 1))
                    pre <= '0;
                else
                    pre <= pre + 1'b1;
            end
            assign tick = (pre == PW'(PRESCALE - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            el_cnt  <= '0;
        end else begin
            if (tick)
                ref_cnt <= ref_cnt + 1'b1;
            if (restart)
                el_cnt <= '0;
            else if (tick)
                el_cnt <= el_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ets_poll.sv
module ets_poll
    import ets_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll,
    input  logic             level,
    input  logic [CNT_W-1:0] ref_cnt,
    input  logic [CNT_W-1:0] el_cnt,
    output logic             snap_level,
    output logic [CNT_W-1:0] snap_ref,
    output logic [CNT_W-1:0] snap_elapsed,
    output logic [CNT_W-1:0] stamp,
    output logic             stamp_valid,
    output logic             poll_done
);
    poll_state_e state_q, state_d;
    logic        last_level;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POLL_IDLE:   if (poll) state_d = POLL_REPORT;
            POLL_REPORT: state_d = POLL_IDLE;
            default:     state_d = POLL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= POLL_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_level   <= 1'b0;
            snap_ref     <= '0;
            snap_elapsed <= '0;
            stamp        <= '0;
            stamp_valid  <= 1'b0;
            poll_done    <= 1'b0;
            last_level   <= 1'b0;
        end else begin
            poll_done <= 1'b0;
            unique case (state_q)
                POLL_IDLE: begin
                    if (poll) begin
                        snap_level   <= level;
                        snap_ref     <= ref_cnt;
                        snap_elapsed <= el_cnt;
                    end
                end
                POLL_REPORT: begin
                    stamp       <= snap_ref - snap_elapsed;
                    stamp_valid <= snap_level & ~last_level;
                    last_level  <= snap_level;
                    poll_done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evt_timestamp.sv
module evt_timestamp #(
    parameter int CNT_W       = 16,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             echo_invert,
    input  logic             poll,
    output logic             snap_level,
    output logic [CNT_W-1:0] snap_ref,
    output logic [CNT_W-1:0] snap_elapsed,
    output logic [CNT_W-1:0] stamp,
    output logic             stamp_valid,
    output logic             poll_done,
    output logic             echo_out
);
    logic             level;
    logic             rise;
    logic             tick;
    logic [CNT_W-1:0] ref_cnt;
    logic [CNT_W-1:0] el_cnt;

    ets_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (evt_in),
        .level (level),
        .rise  (rise)
    );

    ets_timebase #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rise),
        .tick    (tick),
        .ref_cnt (ref_cnt),
        .el_cnt  (el_cnt)
    );

    ets_poll #(.CNT_W(CNT_W)) u_poll (
        .clk          (clk),
        .rst_n        (rst_n),
        .poll         (poll),
        .level        (level),
        .ref_cnt      (ref_cnt),
        .el_cnt       (el_cnt),
        .snap_level   (snap_level),
        .snap_ref     (snap_ref),
        .snap_elapsed (snap_elapsed),
        .stamp        (stamp),
        .stamp_valid  (stamp_valid),
        .poll_done    (poll_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            echo_out <= 1'b0;
        else
            echo_out <= level ^ echo_invert;
    end
endmodule

// File: rtl/evt_timestamp_chk.sv
module evt_timestamp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         rise,
    input logic [W-1:0] ref_cnt,
    input logic [W-1:0] el_cnt,
    input logic         done,
    input logic         valid,
    input logic         level
);
    logic [W-1:0] diff;
    assign diff = ref_cnt - el_cnt;

    assert_clear_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (el_cnt == '0));

    assert_lockstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(diff));

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ref_cnt));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_valid_needs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> level);
endmodule

bind evt_timestamp evt_timestamp_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rise    (rise),
    .ref_cnt (ref_cnt),
    .el_cnt  (el_cnt),
    .done    (poll_done),
    .valid   (stamp_valid),
    .level   (snap_level)
);

// File: tb/evt_timestamp_test.sv
module evt_timestamp_test;
    localparam int W = 8;
    localparam int P = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt_in = 1'b0;
    logic         echo_invert = 1'b0;
    logic         poll = 1'b0;
    logic         snap_level;
    logic [W-1:0] snap_ref, snap_elapsed, stamp;
    logic         stamp_valid, poll_done, echo_out;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    evt_timestamp #(.CNT_W(W), .PRESCALE(P), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .echo_invert(echo_invert),
        .poll(poll), .snap_level(snap_level), .snap_ref(snap_ref),
        .snap_elapsed(snap_elapsed), .stamp(stamp), .stamp_valid(stamp_valid),
        .poll_done(poll_done), .echo_out(echo_out)
    );

    // Reference model built from the requirements
    logic         m_s1, m_s2, m_prev, m_echo;
    logic [W-1:0] m_ref, m_el, m_edge_ref;
    int           m_pre;
    logic         m_last;

    function automatic logic [W-1:0] wsub(logic [W-1:0] a, logic [W-1:0] b);
        return a - b;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_echo <= 0;
            m_ref <= '0; m_el <= '0; m_edge_ref <= '0; m_pre <= 0;
        end else begin
            logic t, r;
            t = (m_pre == P - 1);
            r = m_s2 & ~m_prev;
            m_s1 <= evt_in;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            m_pre <= t ? 0 : m_pre + 1;
            m_ref <= m_ref + W'(t);
            m_el  <= r ? '0 : m_el + W'(t);
            if (r) m_edge_ref <= m_ref + W'(t);
            m_echo <= m_s2 ^ echo_invert;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_poll();
        logic [W-1:0] e_ref, e_el, e_edge;
        logic e_lvl, e_valid;
        @(negedge clk);
        e_ref = m_ref; e_el = m_el; e_lvl = m_s2; e_edge = m_edge_ref;
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        chk(snap_ref == e_ref, "R6", "snap_ref (R3 rate)", int'(snap_ref), int'(e_ref));
        chk(snap_elapsed == e_el, "R6", "snap_elapsed (R2)", int'(snap_elapsed), int'(e_el));
        chk(snap_level == e_lvl, "R6", "snap_level (R1)", int'(snap_level), int'(e_lvl));
        chk(poll_done == 1'b0, "R6", "done early", int'(poll_done), 0);
        @(negedge clk);
        e_valid = e_lvl & ~m_last;
        m_last = e_lvl;
        chk(poll_done == 1'b1, "R6", "done", int'(poll_done), 1);
        chk(stamp == wsub(e_ref, e_el), "R4", "stamp diff", int'(stamp), int'(wsub(e_ref, e_el)));
        chk(stamp == e_edge, "R4", "stamp edge", int'(stamp), int'(e_edge));
        chk(stamp_valid == e_valid, "R7", "valid", int'(stamp_valid), int'(e_valid));
        chk(echo_out == m_echo, "R5", "echo", int'(echo_out), int'(m_echo));
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        m_last = 1'b0;
        void'($urandom(32'd4711));
        // R8: reset state
        #12;
        chk(echo_out == 0, "R8", "echo in reset", int'(echo_out), 0);
        chk(snap_ref == 0 && snap_elapsed == 0, "R8", "snap in reset", int'(snap_ref), 0);
        chk(stamp == 0 && stamp_valid == 0 && poll_done == 0, "R8", "results in reset", int'(stamp), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cycles(5);
        do_poll();                         // no event yet: stamp 0, valid 0

        // R1: a rise still inside the synchroniser is not seen yet
        @(negedge clk); evt_in = 1'b1;
        do_poll();
        chk(stamp_valid == 0, "R1", "early poll sees old level", int'(stamp_valid), 0);
        wait_cycles(4);
        do_poll();                         // R7: new event, valid 1
        chk(stamp_valid == 1, "R7", "first rise", int'(stamp_valid), 1);
        do_poll();                         // R7: still high, no event
        chk(stamp_valid == 0, "R7", "level held high", int'(stamp_valid), 0);
        @(negedge clk); evt_in = 1'b0;
        wait_cycles(4);
        do_poll();
        chk(stamp_valid == 0, "R1", "falling edge gives no event", int'(stamp_valid), 0);

        // R5: inverted echo
        @(negedge clk); echo_invert = 1'b1;
        wait_cycles(2);
        chk(echo_out == 1'b1, "R5", "inverted low level", int'(echo_out), 1);
        @(negedge clk); echo_invert = 1'b0;
        wait_cycles(2);
        chk(echo_out == 1'b0, "R5", "true low level", int'(echo_out), 0);

        // R4: late poll after several counter wraps
        @(negedge clk); evt_in = 1'b1;
        wait_cycles(2000);
        do_poll();
        chk(stamp == m_edge_ref, "R4", "late poll after wrap", int'(stamp), int'(m_edge_ref));

        // R6: poll held for two cycles; second sample ignored
        begin
            logic [W-1:0] first_ref;
            @(negedge clk); first_ref = m_ref; poll = 1'b1;
            @(negedge clk);
            @(negedge clk); poll = 1'b0;
            m_last = 1'b1;
            chk(poll_done == 1'b1, "R6", "done after held poll", int'(poll_done), 1);
            @(negedge clk);
            chk(poll_done == 1'b0, "R6", "no second done", int'(poll_done), 0);
            chk(snap_ref == first_ref, "R6", "snapshot not retaken", int'(snap_ref), int'(first_ref));
        end

        // Random stimulus
        for (int it = 0; it < 400; it++) begin
            int n;
            n = $urandom_range(1, 14);
            for (int c = 0; c < n; c++) begin
                @(negedge clk);
                if ($urandom_range(0, 3) == 0) evt_in = ~evt_in;
                if ($urandom_range(0, 31) == 0) echo_invert = ~echo_invert;
            end
            do_poll();
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule